// File: doc/BRIEF.md
# Interrupt Priority Level Evaluator

This block decides whether a pending interrupt is urgent enough to interrupt the processor. It takes a software request word, a small vector of external interrupt lines and the processor's current priority level. It reduces all pending sources to one numeric priority level, and it builds a summary word with one bit for each pending source. The software sources and the external lines share a single level space.

Evaluation does not run continuously. A request pulse arms an internal check flag. In the next cycle the block evaluates the inputs present at that moment and then clears the flag. If the winning level is higher than the current level, the block raises a one-cycle trap request. In the same cycle it captures the summary word and the winning level in its output registers. Delivering the trap and clearing the interrupt sources are the job of the surrounding logic.

Top module: `ipl_eval`

## Requirements
- R1: While reset is high, and right after it, `trap_req` is 0, and `summary` and `int_id` are 0.
- R2: Only bits 4 through 18 of `sw_req` take part. A bit set outside that range changes neither the level nor the summary.
- R3: A set software bit at position i (4 to 18) has level i-3, so bit 4 is level 1 and bit 18 is level 15. It sets summary bit i.
- R4: External line k sets summary bit 20+k. It has the level held in field k of the parameter `EXT_LVL`. The default levels for lines 0 to 5 are 20, 21, 22, 23, 29 and 31.
- R5: When several sources are pending, the selected level is the highest level among them.
- R6: A trap is requested only when the selected level is nonzero and strictly greater than the 5-bit `cur_ipl`. A level equal to `cur_ipl` gives no trap.
- R7: When a trap is requested, `summary` takes the bits of every pending source, and `int_id` takes the selected level. Both are valid in the same cycle as the `trap_req` pulse.
- R8: When an evaluation takes no trap, `summary` and `int_id` keep their previous values.
- R9: A `check_req` pulse in cycle n causes one evaluation, in cycle n+1, on the inputs of cycle n+1. `trap_req` is high only in cycle n+2. Without `check_req`, no trap is raised, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| check_req | input | 1 | Arms the check flag for one evaluation |
| sw_req | input | 32 | Software request word; bits 4..18 are used |
| ext_irq | input | 6 | External interrupt lines |
| cur_ipl | input | 5 | Current processor priority level |
| trap_req | output | 1 | One-cycle interrupt trap request |
| summary | output | 32 | Captured pending-source summary |
| int_id | output | 5 | Captured selected level |

## Verification
The hardest case to reach is the boundary between trap and no trap. Here the highest pending level is exactly equal to `cur_ipl`, or one above it, while lower sources of both kinds are also pending. Random stimulus seldom lands on that boundary. Directed cases therefore set `cur_ipl` to the level of the top source and to one less. Random rounds draw `cur_ipl` from just around the computed level. A second difficulty is the register-hold rule. The bench checks it by running a no-trap evaluation directly after a trap and comparing the outputs with the values captured earlier.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
  localparam int LVL_W = 5;
  typedef logic [LVL_W-1:0] lvl_t;

  // Larger of two levels
  function automatic lvl_t lvl_max(lvl_t a, lvl_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ipl_sw_decode.sv
module ipl_sw_decode
  import ipl_pkg::*;
#(
  parameter int SUM_W = 32,
  parameter int SW_LO = 4,
  parameter int SW_HI = 18
) (
  input  logic [SUM_W-1:0] sw_req,
  output logic [SUM_W-1:0] sw_bits,
  output lvl_t             sw_lvl
);
  localparam logic [SUM_W-1:0] SW_MASK =
    ((SUM_W'(1) << (SW_HI + 1)) - SUM_W'(1)) & ~((SUM_W'(1) << SW_LO) - SUM_W'(1));

  assign sw_bits = sw_req & SW_MASK;

  // Highest set bit wins; level is position relative to the lowest bit, plus one
  always_comb begin
    sw_lvl = '0;
    for (int i = SW_LO; i <= SW_HI; i++) begin
      if (sw_bits[i]) sw_lvl = lvl_t'(i - SW_LO + 1);
    end
  end
endmodule

// File: rtl/ipl_ext_decode.sv
module ipl_ext_decode
  import ipl_pkg::*;
#(
  parameter int                       SUM_W   = 32,
  parameter int                       NUM_EXT = 6,
  parameter int                       EXT_LO  = 20,
  parameter logic [NUM_EXT*LVL_W-1:0] EXT_LVL = '0
) (
  input  logic [NUM_EXT-1:0] ext_irq,
  output logic [SUM_W-1:0]   ext_bits,
  output lvl_t               ext_lvl
);
  lvl_t cand [NUM_EXT];

  for (genvar k = 0; k < NUM_EXT; k++) begin : g_line
    assign cand[k] = ext_irq[k] ? EXT_LVL[k*LVL_W +: LVL_W] : '0;
  end

  always_comb begin
    ext_bits = '0;
    ext_lvl  = '0;
    for (int k = 0; k < NUM_EXT; k++) begin
      ext_bits[EXT_LO + k] = ext_irq[k];
      ext_lvl = lvl_max(ext_lvl, cand[k]);
    end
  end
endmodule

// File: rtl/ipl_eval.sv
module ipl_eval
  import ipl_pkg::*;
#(
  parameter int                       SUM_W   = 32,
  parameter int                       SW_LO   = 4,
  parameter int                       SW_HI   = 18,
  parameter int                       NUM_EXT = 6,
  parameter int                       EXT_LO  = 20,
  parameter logic [NUM_EXT*LVL_W-1:0] EXT_LVL =
    {5'd31, 5'd29, 5'd23, 5'd22, 5'd21, 5'd20}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               check_req,
  input  logic [SUM_W-1:0]   sw_req,
  input  logic [NUM_EXT-1:0] ext_irq,
  input  logic [LVL_W-1:0]   cur_ipl,
  output logic               trap_req,
  output logic [SUM_W-1:0]   summary,
  output logic [LVL_W-1:0]   int_id
);
  localparam logic [SUM_W-1:0] VALID_MASK =
    (((SUM_W'(1) << (SW_HI + 1)) - SUM_W'(1)) & ~((SUM_W'(1) << SW_LO) - SUM_W'(1)))
    | (((SUM_W'(1) << NUM_EXT) - SUM_W'(1)) << EXT_LO);

  logic [SUM_W-1:0] sw_bits, ext_bits;
  lvl_t             sw_lvl, ext_lvl, sel_lvl;
  logic             chk_flag;
  logic             take;

  ipl_sw_decode #(.SUM_W(SUM_W), .SW_LO(SW_LO), .SW_HI(SW_HI)) u_sw (
    .sw_req (sw_req),
    .sw_bits(sw_bits),
    .sw_lvl (sw_lvl)
  );

  ipl_ext_decode #(.SUM_W(SUM_W), .NUM_EXT(NUM_EXT), .EXT_LO(EXT_LO),
                   .EXT_LVL(EXT_LVL)) u_ext (
    .ext_irq (ext_irq),
    .ext_bits(ext_bits),
    .ext_lvl (ext_lvl)
  );

  assign sel_lvl = lvl_max(sw_lvl, ext_lvl);
  assign take    = chk_flag && (sel_lvl != '0) && (sel_lvl > cur_ipl);

  // Check flag: armed by a request, consumed by the evaluation that follows
  always_ff @(posedge clk) begin
    if (rst) chk_flag <= 1'b0;
    else     chk_flag <= check_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_req <= 1'b0;
      summary  <= '0;
      int_id   <= '0;
    end else begin
      trap_req <= take;
      if (take) begin
        summary <= sw_bits | ext_bits;
        int_id  <= sel_lvl;
      end
    end
  end

  // A trap needs an armed flag one cycle earlier (R9)
  p_flag_before_trap_r9: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> $past(chk_flag));

  // The captured level beats the priority level seen at evaluation (R6)
  p_strict_gt_r6: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> (int_id > $past(cur_ipl)) && (int_id != '0));

  // Without a trap the captured registers hold (R8)
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !trap_req |-> $stable(summary) && $stable(int_id));

  // Summary carries only bits of real sources (R2)
  p_sum_mask_r2: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> ((summary & ~VALID_MASK) == '0));

  // Selected level never falls below either decoded level (R5)
  p_sel_max_r5: assert property (@(posedge clk) disable iff (rst)
    (sel_lvl >= sw_lvl) && (sel_lvl >= ext_lvl));
endmodule

// File: tb/ipl_eval_tb.sv
module ipl_eval_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        check_req;
  logic [31:0] sw_req;
  logic [5:0]  ext_irq;
  logic [4:0]  cur_ipl;
  logic        trap_req;
  logic [31:0] summary;
  logic [4:0]  int_id;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_sum;
  logic [4:0]  exp_id;

  always #2.5 clk = ~clk;

  ipl_eval u_dut (
    .clk(clk), .rst(rst), .check_req(check_req), .sw_req(sw_req),
    .ext_irq(ext_irq), .cur_ipl(cur_ipl), .trap_req(trap_req),
    .summary(summary), .int_id(int_id)
  );

  function automatic logic [4:0] ext_level(int k);
    case (k)
      0: return 5'd20; 1: return 5'd21; 2: return 5'd22;
      3: return 5'd23; 4: return 5'd29; default: return 5'd31;
    endcase
  endfunction

  function automatic logic [4:0] model_lvl(logic [31:0] s, logic [5:0] e);
    logic [4:0] l = '0;
    for (int i = 4; i <= 18; i++) if (s[i]) l = 5'(i - 3);
    for (int k = 0; k < 6; k++) if (e[k] && ext_level(k) > l) l = ext_level(k);
    return l;
  endfunction

  function automatic logic [31:0] model_sum(logic [31:0] s, logic [5:0] e);
    return (s & 32'h0007_fff0) | ({26'd0, e} << 20);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Pulse the request, hold inputs, sample the registered result
  task automatic run(string req, logic [31:0] s, logic [5:0] e, logic [4:0] ipl);
    logic [4:0] l;
    logic       t;
    @(negedge clk);
    sw_req = s; ext_irq = e; cur_ipl = ipl; check_req = 1'b1;
    @(negedge clk);
    check_req = 1'b0;
    @(negedge clk);
    l = model_lvl(s, e);
    t = (l != 0) && (l > ipl);
    if (t) begin exp_sum = model_sum(s, e); exp_id = l; end
    check({req, " trap"}, 64'(trap_req), 64'(t));
    check({req, " summary"}, 64'(summary), 64'(exp_sum));
    check({req, " id"}, 64'(int_id), 64'(exp_id));
    @(negedge clk);
    check({req, " R9 pulse"}, 64'(trap_req), 64'd0);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; check_req = 1'b0; sw_req = '0; ext_irq = '0; cur_ipl = '0;
    exp_sum = '0; exp_id = '0;
    repeat (3) @(negedge clk);
    check("R1 trap", 64'(trap_req), 64'd0);
    check("R1 summary", 64'(summary), 64'd0);
    check("R1 id", 64'(int_id), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", 64'(int_id), 64'd0);

    run("R2 out of range", 32'hfff8_000f, 6'd0, 5'd0);
    run("R3 lowest sw", 32'h0000_0010, 6'd0, 5'd0);
    check("R3 level1", 64'(int_id), 64'd1);
    run("R3 highest sw", 32'h0004_0000, 6'd0, 5'd14);
    check("R3 level15", 64'(int_id), 64'd15);
    run("R4 ext line5", 32'd0, 6'b100000, 5'd30);
    run("R6 equal level", 32'd0, 6'b010000, 5'd29);
    run("R8 hold after no trap", 32'h0000_0100, 6'd0, 5'd20);
    run("R5 mixed", 32'h0007_fff0, 6'b001001, 5'd22);
    run("R6 one above", 32'h0000_2000, 6'd0, 5'd9);
    run("R7 all sources", 32'hffff_ffff, 6'b111111, 5'd0);

    // R9: no request, high pending level, no trap
    @(negedge clk);
    sw_req = 32'h0004_0000; ext_irq = 6'b111111; cur_ipl = 5'd0;
    repeat (4) @(negedge clk);
    check("R9 no request", 64'(trap_req), 64'd0);
    check("R9 regs unchanged", 64'(summary), 64'(exp_sum));

    for (int n = 0; n < 300; n++) begin
      logic [31:0] s;
      logic [5:0]  e;
      logic [4:0]  l, ipl;
      s = $urandom;
      if ($urandom_range(0, 1) == 0) s = s & ($urandom | $urandom);
      e = ($urandom_range(0, 2) == 0) ? 6'($urandom) : 6'd0;
      l = model_lvl(s, e);
      case ($urandom_range(0, 3))
        0: ipl = l;
        1: ipl = (l == 0) ? 5'd0 : l - 5'd1;
        default: ipl = 5'($urandom);
      endcase
      run("R5 R6 R7 R8 random", s, e, ipl);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule